// File: doc/BRIEF.md
# Table Pointer Memory Access Unit

This block moves single bytes between a byte-addressed program memory and an 8-bit data latch for a processor core. A 22-bit pointer, made of three byte registers that the core reads and writes one at a time, selects the byte. The low 21 bits reach up to 2 MB of main memory. The top bit selects a separate space for identification and configuration bytes.

The core issues commands. A table read fetches one byte into the latch. A table write puts the latch byte into one of eight holding registers. A long write commits the whole holding bank to an aligned 8-byte memory block. An erase clears an aligned 64-byte block. Reads and writes carry one of four pointer-update modes. A simple request/ready port drives the memory array.

The controller is a four-state machine. In `ST_IDLE` it accepts a command. On a read it goes to `ST_RD_WAIT`, on a long write to `ST_WR_WAIT` and on an erase to `ST_ER_WAIT`. A table write finishes in `ST_IDLE` and stays there. Each wait state goes back to `ST_IDLE` in the cycle that `mem_ready` is high.

Top module: `tbl_access_unit`

## Requirements
- R1: After reset the pointer is 0, the latch is 0, every holding register is 8'hFF, and `busy` is low while `cmd_ready` is high.
- R2: `reg_sel` selects 0 for pointer bits [7:0], 1 for bits [15:8], 2 for the upper byte and 3 for the latch. A register write changes only the selected byte. The upper byte keeps its bits [5:0] and reads back with zeros in bits [7:6]. A register write takes effect only in `ST_IDLE` while `cmd_valid` is low.
- R3: The `cmd_mode` values are: 0 leaves the pointer unchanged, 1 increments it after the access, 2 decrements it after the access, and 3 increments it before the access. Mode 3 accesses the updated pointer. The other modes access the old pointer. Long write and erase ignore the mode and leave the pointer unchanged.
- R4: An update changes only pointer bits [20:0] and wraps within 21 bits. Bit 21 is never changed by an update.
- R5: A read (`cmd_op`=1) presents all 22 access-address bits with `mem_cmd`=0. It loads `mem_rdata` into the latch in the cycle that `mem_ready` is high.
- R6: A table write (`cmd_op`=2) copies the latch into the holding register indexed by access-address bits [2:0]. It causes no memory request.
- R7: A long write (`cmd_op`=3) requests `mem_cmd`=1 at the pointer with bits [2:0] cleared. Holding register i is sent on `mem_wdata[8i+7:8i]`. On completion every holding register returns to 8'hFF.
- R8: An erase (`cmd_op`=4) requests `mem_cmd`=2 at the pointer with bits [5:0] cleared.
- R9: While `busy` is high, `cmd_ready` is low and commands and register writes have no effect.
- R10: A memory request keeps its address and command stable until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cmd_valid | input | 1 | command strobe |
| cmd_op | input | 3 | 0 none, 1 read, 2 table write, 3 long write, 4 erase |
| cmd_mode | input | 2 | pointer-update mode |
| cmd_ready | output | 1 | a command can be taken this cycle |
| busy | output | 1 | waiting on memory |
| reg_wr_en | input | 1 | register write strobe |
| reg_sel | input | 2 | register select |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | selected register value |
| mem_req | output | 1 | memory request |
| mem_cmd | output | 2 | 0 read, 1 block write, 2 erase |
| mem_addr | output | 22 | memory byte address |
| mem_wdata | output | 64 | holding bank contents |
| mem_rdata | input | 8 | read data |
| mem_ready | input | 1 | memory done |

## Verification
Reads run in each of the four modes over two adjacent bytes that hold different values. This shows whether the access used the old or the updated pointer. Pointers at 0x1FFFFF, 0x200000 and 0x3FFFFF exercise the 21-bit wrap and show that bit 21 is held. Holding writes at known indices are committed from unaligned pointers, with marker bytes placed on both sides of each block, so that indexing, alignment masking and the clearing of the bank show up as distinct errors. A command and a register write driven during a pending read show whether anything leaks through while the unit is busy.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_LONGW = 3'd3,
        OP_ERASE = 3'd4
    } tbl_op_e;

    typedef enum logic [1:0] {
        MD_HOLD    = 2'd0,
        MD_POSTINC = 2'd1,
        MD_POSTDEC = 2'd2,
        MD_PREINC  = 2'd3
    } tbl_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_WR_WAIT = 2'd2,
        ST_ER_WAIT = 2'd3
    } tbl_state_e;

    localparam logic [1:0] MEM_RD = 2'd0;
    localparam logic [1:0] MEM_WR = 2'd1;
    localparam logic [1:0] MEM_ER = 2'd2;
endpackage

// File: rtl/tbl_ptr_next.sv
module tbl_ptr_next #(
    parameter int PTR_W = 22
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [1:0]       mode,
    output logic [PTR_W-1:0] ptr_new,
    output logic [PTR_W-1:0] acc_addr
);
    import tbl_pkg::*;
    localparam int LOW_W = PTR_W - 1;

    logic [LOW_W-1:0] low_nxt;

    always_comb begin
        unique case (tbl_mode_e'(mode))
            MD_HOLD:    low_nxt = ptr[LOW_W-1:0];
            MD_POSTINC: low_nxt = ptr[LOW_W-1:0] + 1'b1;
            MD_POSTDEC: low_nxt = ptr[LOW_W-1:0] - 1'b1;
            MD_PREINC:  low_nxt = ptr[LOW_W-1:0] + 1'b1;
            default:    low_nxt = ptr[LOW_W-1:0];
        endcase
        ptr_new  = {ptr[PTR_W-1], low_nxt};
        acc_addr = (tbl_mode_e'(mode) == MD_PREINC) ? ptr_new : ptr;
    end
endmodule

// File: rtl/tbl_hold_bank.sv
module tbl_hold_bank #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             clear,
    output logic [N*8-1:0]   bank
);
    logic [7:0] hold_q [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 hold_q[g] <= 8'hFF;
            else if (clear)                             hold_q[g] <= 8'hFF;
            else if (wr_en && (wr_idx == IDX_W'(g)))    hold_q[g] <= wr_data;
        end
        assign bank[g*8 +: 8] = hold_q[g];
    end

    // R7
    bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bank == {N{8'hFF}}));
    // R6
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> (hold_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit #(
    parameter int PTR_W   = 22,
    parameter int HOLD_N  = 8,
    parameter int ERASE_N = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [1:0]          cmd_mode,
    output logic                cmd_ready,
    output logic                busy,
    input  logic                reg_wr_en,
    input  logic [1:0]          reg_sel,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic                mem_req,
    output logic [1:0]          mem_cmd,
    output logic [PTR_W-1:0]    mem_addr,
    output logic [HOLD_N*8-1:0] mem_wdata,
    input  logic [7:0]          mem_rdata,
    input  logic                mem_ready
);
    import tbl_pkg::*;
    localparam int HSEL_W = $clog2(HOLD_N);
    localparam int UP_W   = PTR_W - 16;
    localparam logic [PTR_W-1:0] WR_MASK = ~PTR_W'(HOLD_N - 1);
    localparam logic [PTR_W-1:0] ER_MASK = ~PTR_W'(ERASE_N - 1);

    tbl_state_e       state_q, state_d;
    tbl_op_e          op;
    logic [PTR_W-1:0] ptr_q, ptr_new, acc_addr, acc_sel, ptr_wr_val, addr_q;
    logic [7:0]       latch_q;
    logic             cmd_acc, reg_wr_ok, ptr_moves, hold_wr, hold_clr;

    assign op        = tbl_op_e'(cmd_op);
    assign cmd_acc   = cmd_valid && (state_q == ST_IDLE) && (op inside {OP_READ, OP_WRITE, OP_LONGW, OP_ERASE});
    assign reg_wr_ok = reg_wr_en && (state_q == ST_IDLE) && !cmd_valid;
    assign ptr_moves = cmd_acc && (op == OP_READ || op == OP_WRITE);
    assign hold_wr   = cmd_acc && (op == OP_WRITE);
    assign hold_clr  = (state_q == ST_WR_WAIT) && mem_ready;

    tbl_ptr_next #(.PTR_W(PTR_W)) ptr_next_i (
        .ptr(ptr_q), .mode(cmd_mode), .ptr_new(ptr_new), .acc_addr(acc_addr)
    );

    tbl_hold_bank #(.N(HOLD_N)) hold_i (
        .clk(clk), .rst_n(rst_n), .wr_en(hold_wr), .wr_idx(acc_addr[HSEL_W-1:0]),
        .wr_data(latch_q), .clear(hold_clr), .bank(mem_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_acc) begin
                    if (op == OP_READ)       state_d = ST_RD_WAIT;
                    else if (op == OP_LONGW) state_d = ST_WR_WAIT;
                    else if (op == OP_ERASE) state_d = ST_ER_WAIT;
                end
            end
            ST_RD_WAIT, ST_WR_WAIT, ST_ER_WAIT: if (mem_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        busy      = 1'b1;
        mem_req   = 1'b1;
        mem_cmd   = MEM_RD;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                busy      = 1'b0;
                mem_req   = 1'b0;
            end
            ST_RD_WAIT: mem_cmd = MEM_RD;
            ST_WR_WAIT: mem_cmd = MEM_WR;
            ST_ER_WAIT: mem_cmd = MEM_ER;
            default: mem_cmd = MEM_RD;
        endcase
    end
    assign mem_addr = addr_q;

    // datapath
    always_comb begin
        unique case (op)
            OP_LONGW: acc_sel = ptr_q & WR_MASK;
            OP_ERASE: acc_sel = ptr_q & ER_MASK;
            default:  acc_sel = acc_addr;
        endcase
        ptr_wr_val = ptr_q;
        case (reg_sel)
            2'd0:    ptr_wr_val[7:0]        = reg_wdata;
            2'd1:    ptr_wr_val[15:8]       = reg_wdata;
            2'd2:    ptr_wr_val[PTR_W-1:16] = reg_wdata[UP_W-1:0];
            default: ptr_wr_val = ptr_q;
        endcase
        case (reg_sel)
            2'd0:    reg_rdata = ptr_q[7:0];
            2'd1:    reg_rdata = ptr_q[15:8];
            2'd2:    reg_rdata = 8'(ptr_q[PTR_W-1:16]);
            default: reg_rdata = latch_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            addr_q  <= '0;
            latch_q <= 8'h00;
        end else begin
            if (ptr_moves)                           ptr_q <= ptr_new;
            else if (reg_wr_ok && reg_sel != 2'd3)   ptr_q <= ptr_wr_val;
            if (cmd_acc)                             addr_q <= acc_sel;
            if (state_q == ST_RD_WAIT && mem_ready)  latch_q <= mem_rdata;
            else if (reg_wr_ok && reg_sel == 2'd3)   latch_q <= reg_wdata;
        end
    end

    // R4
    ptr_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_moves |=> (ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1])));
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_cmd)));
    // R7
    wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_cmd == MEM_WR) |-> (mem_addr[HSEL_W-1:0] == '0));
    // R8
    erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_cmd == MEM_ER) |-> ((mem_addr & ~ER_MASK) == '0));
    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_q));
endmodule

// File: tb/tbl_access_unit_tb_top.sv
module tbl_access_unit_tb_top;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_mode = 2'd0;
    logic        cmd_ready, busy;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        mem_req;
    logic [1:0]  mem_cmd;
    logic [21:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_rdata = 8'd0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    logic [7:0] mem_arr [int];
    int   cnt = 0;
    int   commits = 0;
    int   addr_moved = 0;
    logic prev_req = 1'b0;
    logic [21:0] prev_addr = '0;
    logic [21:0] last_addr = '0;

    always #2.5 clk = ~clk;

    tbl_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mode(cmd_mode),
        .cmd_ready(cmd_ready), .busy(busy), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_cmd(mem_cmd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [7:0] peek(int a);
        return mem_arr.exists(a) ? mem_arr[a] : 8'hFF;
    endfunction

    // behavioural memory
    always @(posedge clk) begin
        if (mem_req && prev_req && mem_addr != prev_addr) addr_moved++;
        prev_req  = mem_req;
        prev_addr = mem_addr;
        if (mem_ready) begin
            mem_ready <= 1'b0;
            cnt = 0;
            commits++;
            last_addr = mem_addr;
            if (mem_cmd == 2'd1)
                for (int i = 0; i < 8; i++) mem_arr[int'(mem_addr) + i] = mem_wdata[i*8 +: 8];
            else if (mem_cmd == 2'd2)
                for (int i = 0; i < 64; i++) mem_arr[int'(mem_addr) + i] = 8'hFF;
        end else if (mem_req) begin
            if (cnt == LAT - 1) begin
                mem_ready <= 1'b1;
                mem_rdata <= peek(int'(mem_addr));
            end
            cnt++;
        end else begin
            cnt = 0;
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] s, logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic set_ptr(logic [21:0] p);
        reg_write(2'd0, p[7:0]);
        reg_write(2'd1, p[15:8]);
        reg_write(2'd2, {2'b00, p[21:16]});
    endtask

    task automatic get_ptr(output logic [21:0] p);
        logic [7:0] b0, b1, b2;
        reg_read(2'd0, b0);
        reg_read(2'd1, b1);
        reg_read(2'd2, b2);
        p = {b2[5:0], b1, b0};
    endtask

    task automatic issue(logic [2:0] op, logic [1:0] md);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mode = md;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [21:0] p;
        logic [7:0]  l;
        chk("R1 busy", 32'(busy), 0);
        chk("R1 cmd_ready", 32'(cmd_ready), 1);
        get_ptr(p);
        chk("R1 ptr", 32'(p), 0);
        reg_read(2'd3, l);
        chk("R1 latch", 32'(l), 0);
    endtask

    task automatic t_regs();
        logic [7:0] b;
        set_ptr(22'h2A5C3E);
        reg_read(2'd0, b); chk("R2 low", 32'(b), 32'h3E);
        reg_read(2'd1, b); chk("R2 high", 32'(b), 32'h5C);
        reg_read(2'd2, b); chk("R2 upper", 32'(b), 32'h2A);
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, b); chk("R2 upper mask", 32'(b), 32'h3F);
        reg_read(2'd0, b); chk("R2 low kept", 32'(b), 32'h3E);
    endtask

    task automatic t_read_modes();
        logic [21:0] p;
        logic [7:0]  l;
        mem_arr[32'h123] = 8'hA5;
        mem_arr[32'h124] = 8'h3C;
        set_ptr(22'h000123);
        issue(3'd1, 2'd0);
        reg_read(2'd3, l); chk("R5 R3 hold latch", 32'(l), 32'hA5);
        get_ptr(p); chk("R3 hold ptr", 32'(p), 32'h123);
        chk("R5 read addr", 32'(last_addr), 32'h123);
        issue(3'd1, 2'd1);
        reg_read(2'd3, l); chk("R3 postinc latch", 32'(l), 32'hA5);
        get_ptr(p); chk("R3 postinc ptr", 32'(p), 32'h124);
        issue(3'd1, 2'd2);
        reg_read(2'd3, l); chk("R3 postdec latch", 32'(l), 32'h3C);
        get_ptr(p); chk("R3 postdec ptr", 32'(p), 32'h123);
        issue(3'd1, 2'd3);
        reg_read(2'd3, l); chk("R3 preinc latch", 32'(l), 32'h3C);
        get_ptr(p); chk("R3 preinc ptr", 32'(p), 32'h124);
        set_ptr(22'h000300);
        issue(3'd1, 2'd0);
        reg_read(2'd3, l); chk("R5 blank byte", 32'(l), 32'hFF);
    endtask

    task automatic t_wrap();
        logic [21:0] p;
        logic [7:0]  l;
        mem_arr[32'h200000] = 8'h6B;
        set_ptr(22'h1FFFFF);
        issue(3'd1, 2'd1);
        get_ptr(p); chk("R4 inc wrap", 32'(p), 32'h000000);
        chk("R4 inc wrap addr", 32'(last_addr), 32'h1FFFFF);
        set_ptr(22'h200000);
        issue(3'd1, 2'd2);
        get_ptr(p); chk("R4 dec wrap bit21", 32'(p), 32'h3FFFFF);
        chk("R4 dec wrap addr", 32'(last_addr), 32'h200000);
        issue(3'd1, 2'd3);
        get_ptr(p); chk("R4 preinc wrap", 32'(p), 32'h200000);
        chk("R4 R5 preinc wrap addr", 32'(last_addr), 32'h200000);
        reg_read(2'd3, l); chk("R5 id space byte", 32'(l), 32'h6B);
    endtask

    task automatic t_write_commit();
        logic [21:0] p;
        int c0;
        set_ptr(22'h000100);
        c0 = commits;
        for (int i = 0; i < 8; i++) begin
            reg_write(2'd3, 8'(8'h40 + i));
            issue(3'd2, 2'd1);
        end
        chk("R6 no mem traffic", 32'(commits - c0), 0);
        get_ptr(p); chk("R3 R6 write postinc ptr", 32'(p), 32'h108);
        mem_arr[32'h107] = 8'h5E;
        mem_arr[32'h110] = 8'h5F;
        set_ptr(22'h00010D);
        issue(3'd3, 2'd1);
        chk("R7 block addr", 32'(last_addr), 32'h108);
        chk("R7 byte0", 32'(peek(32'h108)), 32'h40);
        chk("R7 byte7", 32'(peek(32'h10F)), 32'h47);
        chk("R7 below block", 32'(peek(32'h107)), 32'h5E);
        chk("R7 above block", 32'(peek(32'h110)), 32'h5F);
        get_ptr(p); chk("R3 R7 ptr kept", 32'(p), 32'h10D);
        set_ptr(22'h000200);
        issue(3'd3, 2'd0);
        chk("R7 bank cleared 0", 32'(peek(32'h200)), 32'hFF);
        chk("R7 bank cleared 7", 32'(peek(32'h207)), 32'hFF);
        set_ptr(22'h000105);
        reg_write(2'd3, 8'h99);
        issue(3'd2, 2'd0);
        set_ptr(22'h000300);
        issue(3'd3, 2'd0);
        chk("R6 index 5", 32'(peek(32'h305)), 32'h99);
        chk("R6 index 4 untouched", 32'(peek(32'h304)), 32'hFF);
    endtask

    task automatic t_erase();
        logic [21:0] p;
        mem_arr[32'h1C0] = 8'h11;
        mem_arr[32'h1FF] = 8'h22;
        mem_arr[32'h1BF] = 8'h33;
        mem_arr[32'h200] = 8'h44;
        set_ptr(22'h0001E7);
        issue(3'd4, 2'd1);
        chk("R8 erase addr", 32'(last_addr), 32'h1C0);
        chk("R8 first byte", 32'(peek(32'h1C0)), 32'hFF);
        chk("R8 last byte", 32'(peek(32'h1FF)), 32'hFF);
        chk("R8 below", 32'(peek(32'h1BF)), 32'h33);
        chk("R8 above", 32'(peek(32'h200)), 32'h44);
        get_ptr(p); chk("R3 R8 ptr kept", 32'(p), 32'h1E7);
    endtask

    task automatic t_busy();
        logic [21:0] p;
        logic [7:0]  l;
        set_ptr(22'h000123);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_mode = 2'd1;
        @(negedge clk);
        cmd_op = 3'd2; cmd_mode = 2'd1;
        chk("R9 busy", 32'(busy), 1);
        chk("R9 cmd_ready low", 32'(cmd_ready), 0);
        cmd_valid = 1'b0;
        reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h55;
        @(negedge clk);
        cmd_valid = 1'b1;
        reg_wr_en = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        get_ptr(p); chk("R9 ptr only read step", 32'(p), 32'h124);
        reg_read(2'd3, l); chk("R9 latch from read", 32'(l), 32'hA5);
        set_ptr(22'h000400);
        issue(3'd3, 2'd0);
        chk("R9 no hold write", 32'(peek(32'h404)), 32'hFF);
        chk("R10 addr stable", 32'(addr_moved), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_read_modes();
        t_wrap();
        t_write_commit();
        t_erase();
        t_busy();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule